// File: doc/BRIEF.md
# Sigma-Delta Fractional Feedback Divide Controller

This block feeds the modulus-control input of a dual-modulus feedback counter in a fractional-N frequency synthesizer. On every phase-detector cycle it emits one integer divide value. Over time those values average to INT + FRAC/2^25. A third-order noise-shaping modulator made of three cascaded 25-bit accumulators produces a small signed offset, from -3 to +4, that is added to the programmed integer word. The modulus is fixed at 2^25.

The fraction is written in two parts. The 13 low bits are staged by a separate strobe. They take effect only when the main load strobe captures the integer word, the 12 high fraction bits and the prescaler mode. The integer word is checked against the floor for the selected prescaler mode (23 or 75). A value below the floor is raised to the floor and flagged. A control bit selects whether each load clears the modulator state. A hold input, used for counter reset or power-down, forces the modulator back to its load state.

Top module: `fracn_sdm_ctrl`

## Requirements
- R1: The applied fraction is frac_hi*2^13 + lo_stage. lo_stage is the frac_lo value captured by the most recent lo_wr. Both parts take effect only at a load.
- R2: A lo_wr with no following load leaves the sequence of div_out values unchanged.
- R3: A load captures int_word, frac_hi and presc_hi. The next pfd_tick already uses the captured values.
- R4: At a load, int_err is set when int_word is below the floor, and cleared otherwise. The floor is 23 when presc_hi=0 and 75 when presc_hi=1. A flagged integer is replaced by the floor. int_err changes only at a load.
- R5: Each pfd_tick that meets neither load nor hold makes div_valid high for exactly the following cycle. div_out is then the applied integer plus an offset in -3..+4, and div_out is 13 bits wide.
- R6: With a fraction of 0 and a cleared state, div_out equals the applied integer on every tick.
- R7: From a cleared state, a fraction of 2^24 gives the offsets 0, +2, -1, +1, repeating every 4 ticks. A fraction of 2^24-1 gives the offsets 0, +1, +1, 0 on the first four ticks.
- R8: Over 64 ticks from a cleared state with a fraction of 2^23, the sum of div_out is within 3 of 64*INT + 16.
- R9: A load with keep_state=0 clears the modulator state, so the next output equals INT. A load with keep_state=1 keeps the state, and the sequence continues where it was.
- R10: While hold is high, no div_valid is produced and the state is cleared. The first output after hold is released equals INT.
- R11: After reset, div_valid=0, int_err=0 and div_out=0.
- R12: A load and a pfd_tick in the same cycle produce no output. The load takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfd_tick | input | 1 | One pulse per phase-detector cycle; advances the modulator |
| load | input | 1 | Captures integer, high fraction, staged low fraction, prescaler mode |
| keep_state | input | 1 | 1: modulator state survives a load; 0: a load clears it |
| hold | input | 1 | Counter reset / power-down: clears state, suppresses output |
| presc_hi | input | 1 | Prescaler mode: 0 selects floor 23, 1 selects floor 75 |
| int_word | input | 12 | Integer part of the divide ratio |
| frac_hi | input | 12 | Upper 12 bits of the 25-bit fraction |
| lo_wr | input | 1 | Stages frac_lo |
| frac_lo | input | 13 | Lower 13 bits of the 25-bit fraction |
| div_out | output | 13 | Divide value for the current reference cycle |
| div_valid | output | 1 | div_out is fresh this cycle |
| int_err | output | 1 | Last loaded integer was below the floor |

## Verification
div_out and div_valid are registered. Both appear on the cycle after the clock edge that samples pfd_tick. int_err and the captured configuration change on the edge that samples load, so the next tick already uses them. The bench changes inputs on the falling edge and reads each result on the following falling edge. Each tick's result is therefore read exactly one register stage after the edge that produced it. One extra falling edge later, the bench checks that div_valid has dropped again.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  typedef logic signed [3:0] ofs_t;

  function automatic ofs_t bit_ofs(input logic b);
    return ofs_t'({3'b000, b});
  endfunction
endpackage

// File: rtl/fracn_cfg.sv
module fracn_cfg #(
  parameter int INT_W  = 12,
  parameter int HI_W   = 12,
  parameter int LO_W   = 13,
  parameter int MIN_LO = 23,
  parameter int MIN_HI = 75,
  localparam int FRAC_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_wr,
  input  logic [LO_W-1:0]   lo_in,
  input  logic              load,
  input  logic [INT_W-1:0]  int_in,
  input  logic [HI_W-1:0]   hi_in,
  input  logic              presc_in,
  output logic [INT_W-1:0]  int_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic              presc_q,
  output logic              err_q
);
  logic [LO_W-1:0]  lo_stage;
  logic [INT_W-1:0] floor_v;

  assign floor_v = presc_in ? INT_W'(MIN_HI) : INT_W'(MIN_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage <= '0;
    end else if (lo_wr) begin
      lo_stage <= lo_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q   <= INT_W'(MIN_LO);
      frac_q  <= '0;
      presc_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (load) begin
      frac_q  <= {hi_in, lo_stage};
      presc_q <= presc_in;
      if (int_in < floor_v) begin
        int_q <= floor_v;
        err_q <= 1'b1;
      end else begin
        int_q <= int_in;
        err_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W-1:0] acc;
  logic [W:0]   ext;

  assign ext   = {1'b0, acc} + {1'b0, addend};
  assign sum   = ext[W-1:0];
  assign carry = ext[W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (adv) begin
      acc <= sum;
    end
  end
endmodule

// File: rtl/fracn_mash_comb.sv
module fracn_mash_comb
  import fracn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       adv,
  input  logic [2:0] cy,
  output ofs_t       ofs
);
  logic c2_d, c3_d, c3_dd;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (adv) begin
      c2_d  <= cy[1];
      c3_d  <= cy[2];
      c3_dd <= c3_d;
    end
  end

  always_comb begin
    ofs = bit_ofs(cy[0])
        + (bit_ofs(cy[1]) - bit_ofs(c2_d))
        + (bit_ofs(cy[2]) - (bit_ofs(c3_d) <<< 1) + bit_ofs(c3_dd));
  end
endmodule

// File: rtl/fracn_sdm_ctrl.sv
module fracn_sdm_ctrl
  import fracn_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int HI_W   = 12,
  parameter int LO_W   = 13,
  parameter int MIN_LO = 23,
  parameter int MIN_HI = 75,
  parameter int ORDER  = 3,
  localparam int FRAC_W = HI_W + LO_W,
  localparam int OUT_W  = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfd_tick,
  input  logic             load,
  input  logic             keep_state,
  input  logic             hold,
  input  logic             presc_hi,
  input  logic [INT_W-1:0] int_word,
  input  logic [HI_W-1:0]  frac_hi,
  input  logic             lo_wr,
  input  logic [LO_W-1:0]  frac_lo,
  output logic [OUT_W-1:0] div_out,
  output logic             div_valid,
  output logic             int_err
);
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              presc_q;
  logic              clr, adv;
  logic [FRAC_W-1:0] stage_in  [ORDER];
  logic [FRAC_W-1:0] stage_sum [ORDER];
  logic [ORDER-1:0]  cy;
  ofs_t              ofs;
  logic signed [OUT_W:0] nxt;

  fracn_cfg #(
    .INT_W(INT_W), .HI_W(HI_W), .LO_W(LO_W), .MIN_LO(MIN_LO), .MIN_HI(MIN_HI)
  ) u_cfg (
    .clk(clk), .rst(rst), .lo_wr(lo_wr), .lo_in(frac_lo), .load(load),
    .int_in(int_word), .hi_in(frac_hi), .presc_in(presc_hi),
    .int_q(int_q), .frac_q(frac_q), .presc_q(presc_q), .err_q(int_err)
  );

  assign clr = hold | (load & ~keep_state);
  assign adv = pfd_tick & ~hold & ~load;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_in[k] = frac_q;
    end else begin : g_next
      assign stage_in[k] = stage_sum[k-1];
    end
    fracn_acc_stage #(.W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .clr(clr), .adv(adv),
      .addend(stage_in[k]), .sum(stage_sum[k]), .carry(cy[k])
    );
  end

  fracn_mash_comb u_comb (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .cy(cy), .ofs(ofs)
  );

  assign nxt = $signed({2'b00, int_q}) + (OUT_W+1)'(ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out   <= '0;
      div_valid <= 1'b0;
    end else begin
      div_valid <= adv;
      if (adv) begin
        div_out <= nxt[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fracn_sdm_chk.sv
module fracn_sdm_chk #(
  parameter int INT_W  = 12,
  parameter int MIN_LO = 23,
  parameter int MIN_HI = 75,
  localparam int OUT_W = INT_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             pfd_tick,
  input logic             load,
  input logic             hold,
  input logic             presc_q,
  input logic [INT_W-1:0] int_q,
  input logic [OUT_W-1:0] div_out,
  input logic             div_valid,
  input logic             int_err
);
  logic signed [OUT_W+1:0] diff;
  assign diff = $signed({2'b00, div_out}) - $signed({3'b000, int_q});

  AST_TICK_VALID: assert property (@(posedge clk) disable iff (rst)
    pfd_tick && !hold && !load |=> div_valid); // R5
  AST_VALID_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    div_valid |-> $past(pfd_tick)); // R5
  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (rst)
    div_valid |-> (diff >= -3 && diff <= 4)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> !div_valid); // R12
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |=> !div_valid); // R10
  AST_INT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    int_q >= (presc_q ? INT_W'(MIN_HI) : INT_W'(MIN_LO))); // R4
  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(int_err)); // R4
endmodule

bind fracn_sdm_ctrl fracn_sdm_chk #(
  .INT_W(INT_W), .MIN_LO(MIN_LO), .MIN_HI(MIN_HI)
) u_chk (
  .clk(clk), .rst(rst), .pfd_tick(pfd_tick), .load(load), .hold(hold),
  .presc_q(presc_q), .int_q(int_q), .div_out(div_out),
  .div_valid(div_valid), .int_err(int_err)
);

// File: tb/tb_fracn_sdm_ctrl.sv
module tb_fracn_sdm_ctrl;
  logic        clk = 1'b0;
  logic        rst, pfd_tick, load, keep_state, hold, presc_hi, lo_wr;
  logic [11:0] int_word, frac_hi;
  logic [12:0] frac_lo;
  logic [12:0] div_out;
  logic        div_valid, int_err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fracn_sdm_ctrl dut (
    .clk(clk), .rst(rst), .pfd_tick(pfd_tick), .load(load),
    .keep_state(keep_state), .hold(hold), .presc_hi(presc_hi),
    .int_word(int_word), .frac_hi(frac_hi), .lo_wr(lo_wr), .frac_lo(frac_lo),
    .div_out(div_out), .div_valid(div_valid), .int_err(int_err)
  );

  localparam int NV = 10;
  localparam int V_INT [NV] = '{100, 100, 20, 50, 75, 23, 4095, 200, 22, 74};
  localparam int V_PRE [NV] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 1};
  localparam int V_HI  [NV] = '{0, 'h800, 0, 0, 'h800, 0, 'h800, 'h7FF, 0, 0};
  localparam int V_LO  [NV] = '{0, 0, 0, 0, 0, 0, 0, 'h1FFF, 0, 0};
  localparam int V_ERR [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 1, 1};
  localparam int V_EFF [NV] = '{100, 100, 23, 75, 75, 23, 4095, 200, 23, 75};
  localparam int V_OFS [NV][4] = '{'{0,0,0,0}, '{0,2,-1,1}, '{0,0,0,0},
    '{0,0,0,0}, '{0,2,-1,1}, '{0,0,0,0}, '{0,2,-1,1}, '{0,1,1,0},
    '{0,0,0,0}, '{0,0,0,0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_cfg(input int iv, input int pre, input int hi,
                             input int lo, input bit keep);
    frac_lo = 13'(lo); lo_wr = 1'b1;
    @(negedge clk);
    lo_wr = 1'b0;
    int_word = 12'(iv); presc_hi = pre[0]; frac_hi = 12'(hi);
    keep_state = keep; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic tick(output int got, output bit vld);
    pfd_tick = 1'b1;
    @(negedge clk);
    pfd_tick = 1'b0;
    vld = div_valid;
    got = int'(div_out);
  endtask

  task automatic tick_chk(input string req, input int exp);
    int g; bit v;
    tick(g, v);
    chk(v, {req, " valid"}, int'(v), 1);
    chk(g == exp, req, g, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int g; bit v; int sum;
    rst = 1; pfd_tick = 0; load = 0; keep_state = 0; hold = 0; presc_hi = 0;
    lo_wr = 0; int_word = 0; frac_hi = 0; frac_lo = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(div_valid == 0, "R11 valid", int'(div_valid), 0);
    chk(int_err == 0, "R11 err", int'(int_err), 0);
    chk(div_out == 0, "R11 out", int'(div_out), 0);

    // Vector table: R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      program_cfg(V_INT[i], V_PRE[i], V_HI[i], V_LO[i], 1'b0);
      chk(int'(int_err) == V_ERR[i], "R4 err flag", int'(int_err), V_ERR[i]);
      for (int k = 0; k < 4; k++) begin
        tick_chk("R3/R6/R7 table", V_EFF[i] + V_OFS[i][k]);
      end
      chk(int'(int_err) == V_ERR[i], "R4 err sticky", int'(int_err), V_ERR[i]);
    end

    // R5: valid lasts one cycle only
    tick(g, v);
    @(negedge clk);
    chk(div_valid == 0, "R5 single valid", int'(div_valid), 0);

    // R9: keep_state=1 continues, keep_state=0 clears
    program_cfg(100, 0, 'h800, 0, 1'b0);
    tick_chk("R9 pre", 100);
    tick_chk("R9 pre", 102);
    program_cfg(100, 0, 'h800, 0, 1'b1);
    tick_chk("R9 keep continues", 99);
    program_cfg(100, 0, 'h800, 0, 1'b0);
    tick_chk("R9 clear restarts", 100);

    // R2: staging low bits alone changes nothing
    tick_chk("R2 pre", 102);
    frac_lo = 13'h1FFF; lo_wr = 1'b1;
    @(negedge clk);
    lo_wr = 1'b0;
    tick_chk("R2 lo_wr ignored", 99);
    tick_chk("R2 lo_wr ignored", 101);
    // R1: a bare load picks up the staged low bits
    frac_hi = 12'h7FF; keep_state = 1'b0; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    tick_chk("R1 assembled", 100);
    tick_chk("R1 assembled", 101);
    tick_chk("R1 assembled", 101);

    // R10: hold suppresses and clears
    program_cfg(100, 0, 'h800, 0, 1'b0);
    tick_chk("R10 pre", 100);
    tick_chk("R10 pre", 102);
    hold = 1'b1;
    tick(g, v);
    chk(v == 0, "R10 no valid in hold", int'(v), 0);
    tick(g, v);
    chk(v == 0, "R10 no valid in hold", int'(v), 0);
    hold = 1'b0;
    tick_chk("R10 restart", 100);
    tick_chk("R10 restart", 102);

    // R12: load and tick together
    load = 1'b1; pfd_tick = 1'b1; keep_state = 1'b1;
    @(negedge clk);
    load = 1'b0; pfd_tick = 1'b0;
    chk(div_valid == 0, "R12 load wins", int'(div_valid), 0);

    // R8: average over 64 ticks, fraction 2^23
    program_cfg(300, 0, 'h400, 0, 1'b0);
    sum = 0;
    for (int k = 0; k < 64; k++) begin
      tick(g, v);
      sum += g;
      if (g < 297 || g > 304) chk(0, "R5 offset range", g, 300);
    end
    chk(sum >= 64*300 + 13 && sum <= 64*300 + 19, "R8 average", sum, 64*300 + 16);

    // R6: zero fraction over a longer run
    program_cfg(500, 1, 0, 0, 1'b0);
    for (int k = 0; k < 16; k++) begin
      tick(g, v);
      if (g != 500) chk(0, "R6 zero fraction", g, 500);
    end
    chk(1'b1, "R6 zero fraction run", 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule